// File: doc/BRIEF.md
# Audio Serial Port Register Bank

This block is the control and status register file of a multi-channel serial audio controller. The controller moves stereo samples in channel pairs. A peripheral bus reaches the register file with single-cycle accesses: one select, one write flag, a byte address, write data, and read data that is valid in the same cycle as the access. The bank contains:

- the global enable, the receive and transmit block enables, the clock enable and the clock configuration;
- a fixed-stride group of registers for each channel pair: per-pair enables, sample resolution, FIFO thresholds, an interrupt mask, latched overrun flags and flush strobes;
- two read-only words that describe the build configuration.

The bank drives plain control levels and one-cycle strobes toward the FIFOs, the serializers and the clock generator. It takes their status back as plain inputs.

Sample data passes through the left and right data words of each pair without storage. A bus write to a data word emits a one-cycle push strobe in the next cycle, carrying the pair, the side and the data. A bus read of a data word returns the FIFO head combinationally and raises a pop strobe in the same cycle. Neither direction has back-pressure. A push into a full transmit FIFO, or a receive FIFO that fills up, is reported back through the overrun event inputs. Those inputs are latched as per-pair overrun flags, which software reads and clears.

Top module: `audio_port_regs`

## Requirements
- R1: After reset:
  - every stored enable, the clock configuration, the resolutions and the thresholds are 0;
  - every pair interrupt mask reads 0x33 (all masked);
  - `irq_o`, all flush strobes and the push strobe are 0.
- R2: Global words read back what was written:
  - the global enable at 0x000, the receive block enable at 0x004, the transmit block enable at 0x008 and the clock enable at 0x00C each hold only bit 0;
  - the clock configuration at 0x010 holds bits [4:0];
  - all other bits read 0.
- R3: While the global enable is 0, the following outputs are 0:
  - `rx_blk_en_o`, `tx_blk_en_o` and `clk_en_o`;
  - every bit of `rx_ch_en_o` and `tx_ch_en_o`.

  The stored enable values are unchanged and still read back.
- R4: Pair n (n < NP) owns words at 0x020 + 0x40*n with these byte offsets:
  - 0x00 left data, 0x04 right data;
  - 0x08 RX enable (bit 0), 0x0C TX enable (bit 0);
  - 0x10 RX resolution [2:0], 0x14 TX resolution [2:0];
  - 0x18 status, 0x1C mask;
  - 0x20 RX overrun, 0x24 TX overrun;
  - 0x28 RX threshold and 0x2C TX threshold, each [TH_W-1:0] with TH_W = log2(FIFO_DEPTH);
  - 0x30 RX flush, 0x34 TX flush.
- R5: A pair's effective RX channel enable is its RX enable AND the receive block enable AND the global enable. The TX channel enable follows the same rule with the transmit enables.
- R6: The status word of a pair has these bits; all other bits read 0:
  - bit 0: RX data available (`rx_avail_i`);
  - bit 1: latched RX overrun;
  - bit 4: TX FIFO at or below threshold (`tx_empty_i`);
  - bit 5: latched TX overrun.
- R7: `irq_o` is the OR over all pairs of (status AND NOT mask). The mask register stores only bits [5:4] (transmit) and [1:0] (receive), and a 1 masks the matching status bit.
- R8: A pulse on an overrun event input sets that pair's flag. Reading the pair's RX overrun word (offset 0x20) or TX overrun word (offset 0x24) returns the flag in bit 0 and clears it. An event in the same cycle as the clearing read leaves the flag set.
- R9: Flush strobes:
  - a write with bit 0 = 1 to a pair flush word pulses that pair's flush output for exactly the one cycle after the write;
  - a write with bit 0 = 1 to 0x014 (receive) or 0x018 (transmit) pulses that direction for all pairs;
  - bit 0 = 0 gives no pulse.
- R10: A write to a data word raises `tx_push_o` for the one cycle after the write. In that cycle `tx_push_pair_o` is the pair, `tx_push_right_o` is 1 for offset 0x04, and `tx_push_data_o` is the written data.
- R11: A read of a data word returns the pair's `rx_left_i` or `rx_right_i` slice in the same cycle. In that cycle `rx_pop_o` = 1, with the pair and side given on `rx_pop_pair_o` and `rx_pop_right_o`.
- R12: Configuration words are read-only.
  - 0x1F4 holds: TX word size code [18:16], pair count code log2(NP) at [10:9] and at [8:7], RX present bit 6, TX present bit 5, master bit 4, FIFO depth code log2(FIFO_DEPTH)-1 at [3:2], bus width code 2 at [1:0].
  - 0x1F0 holds the RX word size code in [2:0].
  - With default parameters the two words read 0x0004057E and 0x00000004.
- R13: Unmapped addresses read as 0 and ignore writes. These include 0x01C, pair offsets 0x38 and above, and addresses that are not word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Access in this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 9 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, same cycle |
| glb_en_o | output | 1 | Global enable |
| rx_blk_en_o | output | 1 | Effective receive block enable |
| tx_blk_en_o | output | 1 | Effective transmit block enable |
| clk_en_o | output | 1 | Effective clock enable |
| clk_cfg_o | output | 5 | Clock configuration |
| rx_ch_en_o | output | NP | Effective RX pair enables |
| tx_ch_en_o | output | NP | Effective TX pair enables |
| rx_res_o | output | NP*3 | RX resolution codes |
| tx_res_o | output | NP*3 | TX resolution codes |
| rx_thr_o | output | NP*TH_W | RX FIFO thresholds |
| tx_thr_o | output | NP*TH_W | TX FIFO thresholds |
| rx_flush_o | output | NP | RX FIFO flush strobes |
| tx_flush_o | output | NP | TX FIFO flush strobes |
| tx_push_o | output | 1 | Transmit sample push strobe |
| tx_push_pair_o | output | PW | Pair of pushed sample |
| tx_push_right_o | output | 1 | Pushed sample is right side |
| tx_push_data_o | output | 32 | Pushed sample |
| rx_pop_o | output | 1 | Receive sample pop strobe |
| rx_pop_pair_o | output | PW | Pair being popped |
| rx_pop_right_o | output | 1 | Popped side is right |
| rx_left_i | input | NP*32 | Left RX FIFO heads |
| rx_right_i | input | NP*32 | Right RX FIFO heads |
| rx_avail_i | input | NP | RX data available per pair |
| tx_empty_i | input | NP | TX FIFO at/below threshold per pair |
| rx_ovr_evt_i | input | NP | RX overrun event pulses |
| tx_ovr_evt_i | input | NP | TX overrun event pulses |
| irq_o | output | 1 | Combined interrupt |

## Verification
The register map is tried with writes of all-ones to narrow fields. This shows whether stored widths are correct, because the upper bits must read 0. Writes to unmapped words, misaligned offsets and read-only words show that decode leaks would corrupt neither storage nor readback.

Enable gating is checked by clearing the block enable and then the global enable, one after the other, while the stored values are read back. This separates gating of the outputs from clearing of storage.

Interrupts are driven by status on one pair while the masks on that pair and another pair differ. This tells mask polarity apart from pair selection.

Overrun flags are read twice in a row, once with an event arriving on the clearing read. This separates clear-on-read from the set-over-clear priority.

// File: rtl/audio_regs_pkg.sv
package audio_regs_pkg;
  localparam int ADDR_W = 9;
  localparam int BUS_W  = 32;

  // global words
  localparam logic [ADDR_W-1:0] GL_GEN  = 9'h000;
  localparam logic [ADDR_W-1:0] GL_RXB  = 9'h004;
  localparam logic [ADDR_W-1:0] GL_TXB  = 9'h008;
  localparam logic [ADDR_W-1:0] GL_CLKE = 9'h00C;
  localparam logic [ADDR_W-1:0] GL_CCR  = 9'h010;
  localparam logic [ADDR_W-1:0] GL_RXFL = 9'h014;
  localparam logic [ADDR_W-1:0] GL_TXFL = 9'h018;
  localparam logic [ADDR_W-1:0] PAIR_BASE = 9'h020;
  localparam logic [ADDR_W-1:0] CFG_LO  = 9'h1F0;
  localparam logic [ADDR_W-1:0] CFG_HI  = 9'h1F4;

  // word index inside a pair group
  localparam logic [3:0] PW_LDATA = 4'd0;
  localparam logic [3:0] PW_RDATA = 4'd1;
  localparam logic [3:0] PW_RXEN  = 4'd2;
  localparam logic [3:0] PW_TXEN  = 4'd3;
  localparam logic [3:0] PW_RXRES = 4'd4;
  localparam logic [3:0] PW_TXRES = 4'd5;
  localparam logic [3:0] PW_STAT  = 4'd6;
  localparam logic [3:0] PW_MASK  = 4'd7;
  localparam logic [3:0] PW_RXOVR = 4'd8;
  localparam logic [3:0] PW_TXOVR = 4'd9;
  localparam logic [3:0] PW_RXTHR = 4'd10;
  localparam logic [3:0] PW_TXTHR = 4'd11;
  localparam logic [3:0] PW_RXFL  = 4'd12;
  localparam logic [3:0] PW_TXFL  = 4'd13;

  localparam logic [5:0] MASK_BITS = 6'h33;
endpackage

// File: rtl/audio_glob_regs.sv
module audio_glob_regs
  import audio_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [4:0]        wdata,
  output logic [BUS_W-1:0]  rd_data,
  output logic              gen_q,
  output logic              rxb_q,
  output logic              txb_q,
  output logic              clke_q,
  output logic [4:0]        ccr_q,
  output logic              rx_flush_all,
  output logic              tx_flush_all
);
  logic wr_s, rd_s;
  assign wr_s = sel & wr;
  assign rd_s = sel & ~wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q  <= 1'b0;
      rxb_q  <= 1'b0;
      txb_q  <= 1'b0;
      clke_q <= 1'b0;
      ccr_q  <= '0;
    end else if (wr_s) begin
      case (addr)
        GL_GEN:  gen_q  <= wdata[0];
        GL_RXB:  rxb_q  <= wdata[0];
        GL_TXB:  txb_q  <= wdata[0];
        GL_CLKE: clke_q <= wdata[0];
        GL_CCR:  ccr_q  <= wdata;
        default: ;
      endcase
    end
  end

  assign rx_flush_all = wr_s && (addr == GL_RXFL) && wdata[0];
  assign tx_flush_all = wr_s && (addr == GL_TXFL) && wdata[0];

  always_comb begin
    rd_data = '0;
    if (rd_s) begin
      case (addr)
        GL_GEN:  rd_data = BUS_W'(gen_q);
        GL_RXB:  rd_data = BUS_W'(rxb_q);
        GL_TXB:  rd_data = BUS_W'(txb_q);
        GL_CLKE: rd_data = BUS_W'(clke_q);
        GL_CCR:  rd_data = BUS_W'(ccr_q);
        default: rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/audio_pair_regs.sv
module audio_pair_regs
  import audio_regs_pkg::*;
#(
  parameter int TH_W = 4,
  localparam int WIN = (TH_W > 6) ? TH_W : 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_sel,
  input  logic             acc_wr,
  input  logic [3:0]       acc_word,
  input  logic [WIN-1:0]   acc_wdata,
  input  logic             flush_rx_all,
  input  logic             flush_tx_all,
  input  logic             gate_rx,
  input  logic             gate_tx,
  input  logic [BUS_W-1:0] rx_left,
  input  logic [BUS_W-1:0] rx_right,
  input  logic             rx_avail,
  input  logic             tx_empty,
  input  logic             rx_ovr_evt,
  input  logic             tx_ovr_evt,
  output logic [BUS_W-1:0] rd_data,
  output logic             rx_en_eff,
  output logic             tx_en_eff,
  output logic [2:0]       rx_res,
  output logic [2:0]       tx_res,
  output logic [TH_W-1:0]  rx_thr,
  output logic [TH_W-1:0]  tx_thr,
  output logic             rx_flush,
  output logic             tx_flush,
  output logic             irq
);
  logic       wr_s, rd_s;
  logic       rx_en_q, tx_en_q, rx_ovr_q, tx_ovr_q;
  logic [5:0] mask_q;
  logic [5:0] status;

  assign wr_s = acc_sel & acc_wr;
  assign rd_s = acc_sel & ~acc_wr;

  assign status = {tx_ovr_q, tx_empty, 2'b00, rx_ovr_q, rx_avail};
  assign irq    = |(status & ~mask_q);

  assign rx_en_eff = rx_en_q & gate_rx;
  assign tx_en_eff = tx_en_q & gate_tx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en_q <= 1'b0;
      tx_en_q <= 1'b0;
      rx_res  <= '0;
      tx_res  <= '0;
      rx_thr  <= '0;
      tx_thr  <= '0;
      mask_q  <= MASK_BITS;
    end else if (wr_s) begin
      case (acc_word)
        PW_RXEN:  rx_en_q <= acc_wdata[0];
        PW_TXEN:  tx_en_q <= acc_wdata[0];
        PW_RXRES: rx_res  <= acc_wdata[2:0];
        PW_TXRES: tx_res  <= acc_wdata[2:0];
        PW_MASK:  mask_q  <= acc_wdata[5:0] & MASK_BITS;
        PW_RXTHR: rx_thr  <= acc_wdata[TH_W-1:0];
        PW_TXTHR: tx_thr  <= acc_wdata[TH_W-1:0];
        default: ;
      endcase
    end
  end

  // overrun flags: a new event outranks the clearing read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_ovr_q <= 1'b0;
      tx_ovr_q <= 1'b0;
    end else begin
      rx_ovr_q <= rx_ovr_evt | (rx_ovr_q & ~(rd_s && acc_word == PW_RXOVR));
      tx_ovr_q <= tx_ovr_evt | (tx_ovr_q & ~(rd_s && acc_word == PW_TXOVR));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_flush <= 1'b0;
      tx_flush <= 1'b0;
    end else begin
      rx_flush <= flush_rx_all | (wr_s && acc_word == PW_RXFL && acc_wdata[0]);
      tx_flush <= flush_tx_all | (wr_s && acc_word == PW_TXFL && acc_wdata[0]);
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_s) begin
      case (acc_word)
        PW_LDATA: rd_data = rx_left;
        PW_RDATA: rd_data = rx_right;
        PW_RXEN:  rd_data = BUS_W'(rx_en_q);
        PW_TXEN:  rd_data = BUS_W'(tx_en_q);
        PW_RXRES: rd_data = BUS_W'(rx_res);
        PW_TXRES: rd_data = BUS_W'(tx_res);
        PW_STAT:  rd_data = BUS_W'(status);
        PW_MASK:  rd_data = BUS_W'(mask_q);
        PW_RXOVR: rd_data = BUS_W'(rx_ovr_q);
        PW_TXOVR: rd_data = BUS_W'(tx_ovr_q);
        PW_RXTHR: rd_data = BUS_W'(rx_thr);
        PW_TXTHR: rd_data = BUS_W'(tx_thr);
        default:  rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/audio_port_regs.sv
module audio_port_regs
  import audio_regs_pkg::*;
#(
  parameter int       NP          = 4,
  parameter int       FIFO_DEPTH  = 16,
  parameter bit [2:0] TX_WS_CODE  = 3'd4,
  parameter bit [2:0] RX_WS_CODE  = 3'd4,
  parameter bit       HAS_TX      = 1'b1,
  parameter bit       HAS_RX      = 1'b1,
  parameter bit       IS_MASTER   = 1'b1,
  localparam int      TH_W        = $clog2(FIFO_DEPTH),
  localparam int      PW          = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel_i,
  input  logic                 bus_wr_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [BUS_W-1:0]     bus_wdata_i,
  output logic [BUS_W-1:0]     bus_rdata_o,
  output logic                 glb_en_o,
  output logic                 rx_blk_en_o,
  output logic                 tx_blk_en_o,
  output logic                 clk_en_o,
  output logic [4:0]           clk_cfg_o,
  output logic [NP-1:0]        rx_ch_en_o,
  output logic [NP-1:0]        tx_ch_en_o,
  output logic [NP*3-1:0]      rx_res_o,
  output logic [NP*3-1:0]      tx_res_o,
  output logic [NP*TH_W-1:0]   rx_thr_o,
  output logic [NP*TH_W-1:0]   tx_thr_o,
  output logic [NP-1:0]        rx_flush_o,
  output logic [NP-1:0]        tx_flush_o,
  output logic                 tx_push_o,
  output logic [PW-1:0]        tx_push_pair_o,
  output logic                 tx_push_right_o,
  output logic [BUS_W-1:0]     tx_push_data_o,
  output logic                 rx_pop_o,
  output logic [PW-1:0]        rx_pop_pair_o,
  output logic                 rx_pop_right_o,
  input  logic [NP*BUS_W-1:0]  rx_left_i,
  input  logic [NP*BUS_W-1:0]  rx_right_i,
  input  logic [NP-1:0]        rx_avail_i,
  input  logic [NP-1:0]        tx_empty_i,
  input  logic [NP-1:0]        rx_ovr_evt_i,
  input  logic [NP-1:0]        tx_ovr_evt_i,
  output logic                 irq_o
);
  localparam int WIN = (TH_W > 6) ? TH_W : 6;
  localparam logic [1:0] CH_CODE = 2'($clog2(NP));
  localparam logic [1:0] FD_CODE = 2'($clog2(FIFO_DEPTH) - 1);
  localparam logic [BUS_W-1:0] CFG_HI_VAL = {13'd0, TX_WS_CODE, 5'd0, CH_CODE, CH_CODE,
                                             HAS_RX, HAS_TX, IS_MASTER, FD_CODE, 2'd2};
  localparam logic [BUS_W-1:0] CFG_LO_VAL = BUS_W'(RX_WS_CODE);
  localparam logic [2:0] NP_L = 3'(NP);

  // ---- address decode ----
  logic [ADDR_W-1:0] off;
  logic [2:0]        pair_sel;
  logic [3:0]        word;
  logic              pair_hit, data_acc;

  assign off      = bus_addr_i - PAIR_BASE;
  assign pair_sel = off[8:6];
  assign word     = off[5:2];
  assign pair_hit = (bus_addr_i >= PAIR_BASE) && (pair_sel < NP_L) &&
                    (word <= PW_TXFL) && (off[1:0] == 2'b00);
  assign data_acc = pair_hit && (word <= PW_RDATA);

  // ---- global words ----
  logic [BUS_W-1:0] glob_rdata;
  logic gen_q, rxb_q, txb_q, clke_q, rx_fl_all, tx_fl_all;

  audio_glob_regs u_glob (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel          (bus_sel_i),
    .wr           (bus_wr_i),
    .addr         (bus_addr_i),
    .wdata        (bus_wdata_i[4:0]),
    .rd_data      (glob_rdata),
    .gen_q        (gen_q),
    .rxb_q        (rxb_q),
    .txb_q        (txb_q),
    .clke_q       (clke_q),
    .ccr_q        (clk_cfg_o),
    .rx_flush_all (rx_fl_all),
    .tx_flush_all (tx_fl_all)
  );

  assign glb_en_o    = gen_q;
  assign rx_blk_en_o = gen_q & rxb_q;
  assign tx_blk_en_o = gen_q & txb_q;
  assign clk_en_o    = gen_q & clke_q;

  // ---- channel pair groups ----
  logic [BUS_W-1:0] pair_rdata [NP];
  logic [NP-1:0]    pair_irq;

  for (genvar n = 0; n < NP; n++) begin : g_pair
    audio_pair_regs #(.TH_W(TH_W)) u_pair (
      .clk          (clk),
      .rst_n        (rst_n),
      .acc_sel      (bus_sel_i && pair_hit && (pair_sel == 3'(n))),
      .acc_wr       (bus_wr_i),
      .acc_word     (word),
      .acc_wdata    (bus_wdata_i[WIN-1:0]),
      .flush_rx_all (rx_fl_all),
      .flush_tx_all (tx_fl_all),
      .gate_rx      (rx_blk_en_o),
      .gate_tx      (tx_blk_en_o),
      .rx_left      (rx_left_i[n*BUS_W +: BUS_W]),
      .rx_right     (rx_right_i[n*BUS_W +: BUS_W]),
      .rx_avail     (rx_avail_i[n]),
      .tx_empty     (tx_empty_i[n]),
      .rx_ovr_evt   (rx_ovr_evt_i[n]),
      .tx_ovr_evt   (tx_ovr_evt_i[n]),
      .rd_data      (pair_rdata[n]),
      .rx_en_eff    (rx_ch_en_o[n]),
      .tx_en_eff    (tx_ch_en_o[n]),
      .rx_res       (rx_res_o[n*3 +: 3]),
      .tx_res       (tx_res_o[n*3 +: 3]),
      .rx_thr       (rx_thr_o[n*TH_W +: TH_W]),
      .tx_thr       (tx_thr_o[n*TH_W +: TH_W]),
      .rx_flush     (rx_flush_o[n]),
      .tx_flush     (tx_flush_o[n]),
      .irq          (pair_irq[n])
    );
  end

  assign irq_o = |pair_irq;

  // ---- read return ----
  always_comb begin
    bus_rdata_o = glob_rdata;
    for (int n = 0; n < NP; n++) bus_rdata_o = bus_rdata_o | pair_rdata[n];
    if (bus_sel_i && !bus_wr_i) begin
      if (bus_addr_i == CFG_HI) bus_rdata_o = CFG_HI_VAL;
      if (bus_addr_i == CFG_LO) bus_rdata_o = CFG_LO_VAL;
    end
  end

  // ---- sample pass-through ----
  assign rx_pop_o       = bus_sel_i && !bus_wr_i && data_acc;
  assign rx_pop_pair_o  = off[6 +: PW];
  assign rx_pop_right_o = word[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_push_o       <= 1'b0;
      tx_push_pair_o  <= '0;
      tx_push_right_o <= 1'b0;
      tx_push_data_o  <= '0;
    end else begin
      tx_push_o <= bus_sel_i && bus_wr_i && data_acc;
      if (bus_sel_i && bus_wr_i && data_acc) begin
        tx_push_pair_o  <= off[6 +: PW];
        tx_push_right_o <= word[0];
        tx_push_data_o  <= bus_wdata_i;
      end
    end
  end
endmodule

// File: rtl/audio_regs_chk.sv
module audio_regs_chk
  import audio_regs_pkg::*;
#(
  parameter int NP = 4,
  parameter int PW = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_sel_i,
  input logic                bus_wr_i,
  input logic [ADDR_W-1:0]   bus_addr_i,
  input logic [BUS_W-1:0]    bus_wdata_i,
  input logic [BUS_W-1:0]    bus_rdata_o,
  input logic                glb_en_o,
  input logic                rx_blk_en_o,
  input logic                tx_blk_en_o,
  input logic                clk_en_o,
  input logic [NP-1:0]       rx_ch_en_o,
  input logic [NP-1:0]       tx_ch_en_o,
  input logic [NP-1:0]       rx_flush_o,
  input logic                tx_push_o,
  input logic [PW-1:0]       tx_push_pair_o,
  input logic                tx_push_right_o,
  input logic [BUS_W-1:0]    tx_push_data_o,
  input logic                rx_pop_o,
  input logic [NP*BUS_W-1:0] rx_left_i
);
  // R3
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en_o |-> (rx_ch_en_o == '0) && (tx_ch_en_o == '0) && !rx_blk_en_o && !tx_blk_en_o && !clk_en_o);

  // R9
  flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel_i && bus_wr_i && bus_addr_i == GL_RXFL && bus_wdata_i[0]) |=> (&rx_flush_o));

  // R10
  push_left0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel_i && bus_wr_i && bus_addr_i == PAIR_BASE) |=>
      tx_push_o && tx_push_pair_o == '0 && !tx_push_right_o && tx_push_data_o == $past(bus_wdata_i));

  // R11
  pop_left0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel_i && !bus_wr_i && bus_addr_i == PAIR_BASE) |-> rx_pop_o && bus_rdata_o == rx_left_i[BUS_W-1:0]);

  // R13
  hole_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel_i && !bus_wr_i && bus_addr_i == 9'h01C) |-> bus_rdata_o == '0);

  // R12
  cfg_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel_i && !bus_wr_i && bus_addr_i == CFG_LO) |-> bus_rdata_o[BUS_W-1:3] == '0);
endmodule

bind audio_port_regs audio_regs_chk #(.NP(NP), .PW(PW)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .bus_sel_i       (bus_sel_i),
  .bus_wr_i        (bus_wr_i),
  .bus_addr_i      (bus_addr_i),
  .bus_wdata_i     (bus_wdata_i),
  .bus_rdata_o     (bus_rdata_o),
  .glb_en_o        (glb_en_o),
  .rx_blk_en_o     (rx_blk_en_o),
  .tx_blk_en_o     (tx_blk_en_o),
  .clk_en_o        (clk_en_o),
  .rx_ch_en_o      (rx_ch_en_o),
  .tx_ch_en_o      (tx_ch_en_o),
  .rx_flush_o      (rx_flush_o),
  .tx_push_o       (tx_push_o),
  .tx_push_pair_o  (tx_push_pair_o),
  .tx_push_right_o (tx_push_right_o),
  .tx_push_data_o  (tx_push_data_o),
  .rx_pop_o        (rx_pop_o),
  .rx_left_i       (rx_left_i)
);

// File: tb/audio_port_regs_tb_top.sv
module audio_port_regs_tb_top;
  localparam int NP = 4;
  localparam int TH_W = 4;
  localparam int PW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic              bus_sel_i = 1'b0, bus_wr_i = 1'b0;
  logic [8:0]        bus_addr_i = '0;
  logic [31:0]       bus_wdata_i = '0;
  logic [31:0]       bus_rdata_o;
  logic              glb_en_o, rx_blk_en_o, tx_blk_en_o, clk_en_o;
  logic [4:0]        clk_cfg_o;
  logic [NP-1:0]     rx_ch_en_o, tx_ch_en_o, rx_flush_o, tx_flush_o;
  logic [NP*3-1:0]   rx_res_o, tx_res_o;
  logic [NP*TH_W-1:0] rx_thr_o, tx_thr_o;
  logic              tx_push_o, tx_push_right_o, rx_pop_o, rx_pop_right_o;
  logic [PW-1:0]     tx_push_pair_o, rx_pop_pair_o;
  logic [31:0]       tx_push_data_o;
  logic [NP*32-1:0]  rx_left_i = '0, rx_right_i = '0;
  logic [NP-1:0]     rx_avail_i = '0, tx_empty_i = '0, rx_ovr_evt_i = '0, tx_ovr_evt_i = '0;
  logic              irq_o;

  audio_port_regs dut_i (.*);

  int tests = 0, fails = 0;
  bit done = 1'b0;
  logic pop_seen, pop_right_seen;
  logic [PW-1:0] pop_pair_seen;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel_i = 1'b1; bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk);
    bus_sel_i = 1'b0; bus_wr_i = 1'b0;
  endtask

  task automatic bus_read(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel_i = 1'b1; bus_wr_i = 1'b0; bus_addr_i = a;
    #1;
    d = bus_rdata_o;
    pop_seen = rx_pop_o; pop_pair_seen = rx_pop_pair_o; pop_right_seen = rx_pop_right_o;
    @(negedge clk);
    bus_sel_i = 1'b0;
  endtask

  // {read, addr, data (write value or expected read), requirement}
  localparam int NV = 25;
  localparam logic [49:0] VEC [NV] = '{
    {1'b0, 9'h010, 32'hFFFF_FFFF, 8'd2},  // R2 clock config 5 bits
    {1'b1, 9'h010, 32'h0000_001F, 8'd2},
    {1'b0, 9'h000, 32'h0000_0001, 8'd2},
    {1'b1, 9'h000, 32'h0000_0001, 8'd2},
    {1'b0, 9'h004, 32'h0000_0003, 8'd2},
    {1'b1, 9'h004, 32'h0000_0001, 8'd2},
    {1'b0, 9'h008, 32'h0000_0001, 8'd2},
    {1'b1, 9'h008, 32'h0000_0001, 8'd2},
    {1'b0, 9'h00C, 32'hFFFF_FFFF, 8'd2},
    {1'b1, 9'h00C, 32'h0000_0001, 8'd2},
    {1'b0, 9'h070, 32'h0000_0005, 8'd4},  // R4 pair1 RX resolution
    {1'b1, 9'h070, 32'h0000_0005, 8'd4},
    {1'b0, 9'h10C, 32'h0000_00FF, 8'd4},  // R4 pair3 TX threshold
    {1'b1, 9'h10C, 32'h0000_000F, 8'd4},
    {1'b0, 9'h0BC, 32'h0000_00FF, 8'd7},  // R7 mask stores 5:4,1:0
    {1'b1, 9'h0BC, 32'h0000_0033, 8'd7},
    {1'b0, 9'h01C, 32'h0000_FFFF, 8'd13}, // R13 hole
    {1'b1, 9'h01C, 32'h0000_0000, 8'd13},
    {1'b0, 9'h058, 32'h0000_0005, 8'd13}, // R13 pair offset 0x38
    {1'b1, 9'h058, 32'h0000_0000, 8'd13},
    {1'b0, 9'h072, 32'h0000_0007, 8'd13}, // R13 misaligned
    {1'b1, 9'h070, 32'h0000_0005, 8'd13},
    {1'b0, 9'h1F4, 32'h0000_0000, 8'd12}, // R12 read-only
    {1'b1, 9'h1F4, 32'h0004_057E, 8'd12},
    {1'b1, 9'h1F0, 32'h0000_0004, 8'd12}
  };

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 glb_en", 32'(glb_en_o), 0);
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 ch_en", 32'({rx_ch_en_o, tx_ch_en_o}), 0);
    chk("R1 flush/push", 32'({rx_flush_o, tx_flush_o, tx_push_o}), 0);
    bus_read(9'h03C, d); chk("R1 mask", d, 32'h33);
    bus_read(9'h010, d); chk("R1 clk cfg", d, 0);

    for (int i = 0; i < NV; i++) begin
      if (!VEC[i][49]) bus_write(VEC[i][48:40], VEC[i][39:8]);
      else begin
        bus_read(VEC[i][48:40], d);
        chk($sformatf("R%0d @%h", VEC[i][7:0], VEC[i][48:40]), d, VEC[i][39:8]);
      end
    end

    // R5 channel enable gating
    bus_write(9'h028, 1); bus_write(9'h02C, 1);
    chk("R5 rx_ch_en", 32'(rx_ch_en_o), 32'h1);
    chk("R5 tx_ch_en", 32'(tx_ch_en_o), 32'h1);
    bus_write(9'h008, 0);
    chk("R5 tx gated by block", 32'({rx_ch_en_o, tx_ch_en_o}), 32'h10);
    bus_write(9'h008, 1);
    // R3 global enable off
    bus_write(9'h000, 0);
    chk("R3 outputs", 32'({rx_ch_en_o, tx_ch_en_o, rx_blk_en_o, tx_blk_en_o, clk_en_o}), 0);
    bus_read(9'h004, d); chk("R3 stored rx blk", d, 1);
    bus_read(9'h028, d); chk("R3 stored ch en", d, 1);
    bus_write(9'h000, 1);
    chk("R3 restored", 32'(tx_ch_en_o), 32'h1);

    // R6 / R7 status and mask
    bus_write(9'h03C, 0);
    rx_avail_i[0] = 1'b1; #1;
    chk("R7 irq unmasked", 32'(irq_o), 1);
    bus_read(9'h038, d); chk("R6 pair0 status", d, 32'h1);
    bus_write(9'h03C, 32'h3);
    chk("R7 irq masked", 32'(irq_o), 0);
    rx_avail_i[0] = 1'b0;
    tx_empty_i[2] = 1'b1; #1;
    chk("R7 pair2 masked", 32'(irq_o), 0);
    bus_write(9'h0BC, 32'h3);
    chk("R7 pair2 tx unmasked", 32'(irq_o), 1);
    bus_read(9'h0B8, d); chk("R6 pair2 status", d, 32'h10);
    tx_empty_i[2] = 1'b0;
    bus_write(9'h0BC, 32'h33);

    // R8 overrun latch and clear-on-read
    @(negedge clk); rx_ovr_evt_i[1] = 1'b1; @(negedge clk); rx_ovr_evt_i[1] = 1'b0;
    bus_read(9'h078, d); chk("R6 rx overrun bit", d, 32'h2);
    bus_read(9'h080, d); chk("R8 rx ovr read", d, 1);
    bus_read(9'h080, d); chk("R8 rx ovr cleared", d, 0);
    @(negedge clk); tx_ovr_evt_i[3] = 1'b1; @(negedge clk); tx_ovr_evt_i[3] = 1'b0;
    @(negedge clk);
    bus_sel_i = 1'b1; bus_wr_i = 1'b0; bus_addr_i = 9'h104; tx_ovr_evt_i[3] = 1'b1;
    #1 d = bus_rdata_o;
    @(negedge clk); bus_sel_i = 1'b0; tx_ovr_evt_i[3] = 1'b0;
    chk("R8 tx ovr read", d, 1);
    bus_read(9'h104, d); chk("R8 event beats clear", d, 1);
    bus_read(9'h104, d); chk("R8 tx ovr cleared", d, 0);

    // R9 flush strobes
    bus_write(9'h090, 1);
    chk("R9 pair1 rx flush", 32'({rx_flush_o, tx_flush_o}), 32'h20);
    @(negedge clk);
    chk("R9 one cycle", 32'({rx_flush_o, tx_flush_o}), 0);
    bus_write(9'h018, 1);
    chk("R9 global tx flush", 32'({rx_flush_o, tx_flush_o}), 32'h0F);
    bus_write(9'h090, 0);
    chk("R9 bit0 clear", 32'({rx_flush_o, tx_flush_o}), 0);

    // R10 push
    bus_write(9'h064, 32'hCAFE_F00D);
    chk("R10 push", 32'({tx_push_o, tx_push_pair_o, tx_push_right_o}), 32'b1011);
    chk("R10 data", tx_push_data_o, 32'hCAFE_F00D);
    @(negedge clk);
    chk("R10 push ends", 32'(tx_push_o), 0);

    // R11 pop
    rx_left_i[2*32 +: 32] = 32'h1234_5678;
    rx_right_i[3*32 +: 32] = 32'h9ABC_DEF0;
    bus_read(9'h0A0, d);
    chk("R11 left data", d, 32'h1234_5678);
    chk("R11 pop", 32'({pop_seen, pop_pair_seen, pop_right_seen}), 32'b1100);
    bus_read(9'h0E4, d);
    chk("R11 right data", d, 32'h9ABC_DEF0);
    chk("R11 pop right", 32'({pop_seen, pop_pair_seen, pop_right_seen}), 32'b1111);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule